// File: doc/BRIEF.md
# Programmable Display Timing Generator

This block paces one display pipe. Software programs six timing words (horizontal and vertical total, blank and sync) plus a source-size word. Each word holds two 16-bit points, each stored as its value minus one. From these the block runs a pixel counter and a line counter and decodes horizontal sync, vertical sync, a blanking flag, a data-enable flag, a frame-start pulse and the current coordinates.

A pipe control word has an enable request bit and a separate running status bit. Software sets or clears the request and polls the status until it follows. Starting and stopping only happen at a frame boundary. The timing words accept writes only while the pipe is fully idle.

A converter turns a standard detailed-timing descriptor (packed 12-bit active and blank counts, 10-bit horizontal and 6-bit vertical sync fields) into the seven timing words. A single load strobe writes all of them at once.

Top module: `disp_timing_gen`

## Requirements
- R1: After reset both counters read 0, the request and running bits are 0, every timing word reads 0, blank_o is 1, and hsync_o, vsync_o, de_o and frame_start_o are 0.
- R2: A write to address 0 sets the enable request from data bit 31. Reading address 0 returns the request in bit 31, the running status in bit 30 and zeros elsewhere. Addresses 1 to 7 return horizontal total, horizontal blank, horizontal sync, vertical total, vertical blank, vertical sync and source size, in that order. Data written to those addresses while idle reads back unchanged in the next cycle.
- R3: A write to addresses 1 to 7 is dropped while either the request bit or the running bit is 1.
- R4: While running, x_o steps from 0 to the high half of the horizontal total word and then wraps to 0. y_o advances by one on each wrap of x_o and wraps to 0 after the high half of the vertical total word. Both hold at 0 while stopped.
- R5: hsync_o (vsync_o) is 1 while running and while the pixel (line) counter lies between the low and the high half of the horizontal (vertical) sync word, both ends included.
- R6: blank_o is 1 while stopped. It is also 1 when either counter is above the low half and at or below the high half of its blank word.
- R7: de_o is 1 only while running with each counter at or below the low half of its total word, which holds the active size minus one.
- R8: One cycle after the enable request is seen, counting starts at (0,0). The running status bit rises one cycle after that.
- R9: When the request is cleared during a frame, counting continues to the last pixel of the last line. The counters then return to 0 and stop, and the running status falls one cycle later.
- R10: An idle descriptor load writes every timing word. Total is active plus blank. Blank runs from active to total. Sync start is active plus offset, and sync end is that plus the pulse width. Source size holds vertical active minus one low and horizontal active minus one high. Descriptor byte layout: byte0/1 hold the low 8 bits of horizontal active/blank, and byte2 holds their high nibbles (active in bits 7:4). Bytes 3 to 5 do the same for the vertical axis. Byte6/7 hold the low 8 bits of horizontal sync offset/width. Byte8 holds the vertical sync offset in bits 7:4 and the width in bits 3:0. Byte9 holds the high bits: horizontal offset 7:6, horizontal width 5:4, vertical offset 3:2, vertical width 1:0. A load takes precedence over a register write in the same cycle.
- R11: A descriptor load is dropped while the request or running bit is 1.
- R12: frame_start_o pulses for exactly the cycles in which the pipe is running at coordinate (0,0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Register write address |
| wr_data_i | input | 32 | Register write data |
| rd_addr_i | input | 3 | Register read address |
| rd_data_o | output | 32 | Register read data (combinational) |
| desc_load_i | input | 1 | Load all timing words from the descriptor |
| desc_i | input | 80 | Detailed-timing descriptor bytes, byte0 in bits 7:0 |
| hsync_o | output | 1 | Horizontal sync |
| vsync_o | output | 1 | Vertical sync |
| blank_o | output | 1 | Blanking flag |
| de_o | output | 1 | Data enable |
| x_o | output | CNT_W | Pixel counter |
| y_o | output | CNT_W | Line counter |
| frame_start_o | output | 1 | First pixel of a frame |
| running_o | output | 1 | Running status (same as bit 30) |

## Verification
The bench uses the default 16-bit counters but programs very short frames: 12 by 6 by direct register writes, then 16 by 6 from a descriptor. A frame then lasts under a hundred cycles, so several full frames, every sync and blank edge, and both wrap points fall within a short run. These frames also allow an enable and a disable to land mid-frame. A second, wide descriptor with nonzero high nibbles and high sync bits is loaded and only read back, which exercises the bit assembly without running a long frame.

// File: rtl/dtg_pkg.sv
package dtg_pkg;
  localparam int REG_W    = 32;
  localparam int HALF_W   = REG_W / 2;
  localparam int AW       = 3;
  localparam int NUM_TW   = 7;
  localparam int DESC_B   = 10;
  localparam int DESC_W   = DESC_B * 8;
  localparam int REQ_BIT  = 31;
  localparam int RUN_BIT  = 30;

  localparam logic [AW-1:0] A_CFG = 3'd0;

  // word index (address - 1) of each timing word
  localparam int W_HTOT = 0;
  localparam int W_HBLK = 1;
  localparam int W_HSYN = 2;
  localparam int W_VTOT = 3;
  localparam int W_VBLK = 4;
  localparam int W_VSYN = 5;
  localparam int W_SRC  = 6;

  typedef logic [NUM_TW-1:0][REG_W-1:0] tw_arr_t;

  function automatic logic [REG_W-1:0] pack_pair(logic [HALF_W-1:0] s, logic [HALF_W-1:0] e);
    return {e - HALF_W'(1), s - HALF_W'(1)};
  endfunction
endpackage

// File: rtl/dtg_desc_conv.sv
module dtg_desc_conv
  import dtg_pkg::*;
(
  input  logic [DESC_W-1:0] desc_i,
  output tw_arr_t           words_o
);
  logic [7:0] b [DESC_B];
  logic [HALF_W-1:0] h_act, h_blk, h_off, h_pw, v_act, v_blk, v_off, v_pw;
  logic [HALF_W-1:0] h_tot, v_tot, h_ss, h_se, v_ss, v_se;

  for (genvar i = 0; i < DESC_B; i++) begin : g_byte
    assign b[i] = desc_i[8*i +: 8];
  end

  always_comb begin
    h_act = HALF_W'({b[2][7:4], b[0]});
    h_blk = HALF_W'({b[2][3:0], b[1]});
    v_act = HALF_W'({b[5][7:4], b[3]});
    v_blk = HALF_W'({b[5][3:0], b[4]});
    h_off = HALF_W'({b[9][7:6], b[6]});
    h_pw  = HALF_W'({b[9][5:4], b[7]});
    v_off = HALF_W'({b[9][3:2], b[8][7:4]});
    v_pw  = HALF_W'({b[9][1:0], b[8][3:0]});
    h_tot = h_act + h_blk;
    v_tot = v_act + v_blk;
    h_ss  = h_act + h_off;
    h_se  = h_ss + h_pw;
    v_ss  = v_act + v_off;
    v_se  = v_ss + v_pw;
    words_o         = '0;
    words_o[W_HTOT] = pack_pair(h_act, h_tot);
    words_o[W_HBLK] = pack_pair(h_act, h_tot);
    words_o[W_HSYN] = pack_pair(h_ss, h_se);
    words_o[W_VTOT] = pack_pair(v_act, v_tot);
    words_o[W_VBLK] = pack_pair(v_act, v_tot);
    words_o[W_VSYN] = pack_pair(v_ss, v_se);
    words_o[W_SRC]  = pack_pair(v_act, h_act);
  end
endmodule

// File: rtl/dtg_regs.sv
module dtg_regs
  import dtg_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [AW-1:0]     wr_addr_i,
  input  logic [REG_W-1:0]  wr_data_i,
  input  logic [AW-1:0]     rd_addr_i,
  output logic [REG_W-1:0]  rd_data_o,
  input  logic              desc_load_i,
  input  tw_arr_t           desc_words_i,
  input  logic              stat_i,
  output logic              req_o,
  output tw_arr_t           tw_o
);
  logic    req_q;
  tw_arr_t tw_q;
  logic    idle;
  logic [AW-1:0] widx, ridx;

  assign idle = !req_q && !stat_i;
  assign widx = wr_addr_i - AW'(1);
  assign ridx = rd_addr_i - AW'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q <= 1'b0;
      tw_q  <= '0;
    end else begin
      if (wr_en_i && wr_addr_i == A_CFG) req_q <= wr_data_i[REQ_BIT];
      if (idle) begin
        if (desc_load_i) tw_q <= desc_words_i;
        else if (wr_en_i && wr_addr_i != A_CFG) tw_q[widx] <= wr_data_i;
      end
    end
  end

  always_comb begin
    rd_data_o = '0;
    if (rd_addr_i == A_CFG) begin
      rd_data_o[REQ_BIT] = req_q;
      rd_data_o[RUN_BIT] = stat_i;
    end else begin
      rd_data_o = tw_q[ridx];
    end
  end

  assign req_o = req_q;
  assign tw_o  = tw_q;
endmodule

// File: rtl/dtg_counters.sv
module dtg_counters #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic [CNT_W-1:0] h_last_i,
  input  logic [CNT_W-1:0] v_last_i,
  output logic             run_o,
  output logic             stat_o,
  output logic [CNT_W-1:0] h_o,
  output logic [CNT_W-1:0] v_o
);
  logic             run_q, stat_q;
  logic [CNT_W-1:0] h_q, v_q;
  logic             h_wrap, v_wrap;

  assign h_wrap = h_q == h_last_i;
  assign v_wrap = v_q == v_last_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q  <= 1'b0;
      stat_q <= 1'b0;
      h_q    <= '0;
      v_q    <= '0;
    end else begin
      stat_q <= run_q;
      if (!run_q) begin
        run_q <= req_i;
        h_q   <= '0;
        v_q   <= '0;
      end else begin
        if (h_wrap && v_wrap && !req_i) run_q <= 1'b0;
        if (h_wrap) begin
          h_q <= '0;
          v_q <= v_wrap ? '0 : v_q + CNT_W'(1);
        end else begin
          h_q <= h_q + CNT_W'(1);
        end
      end
    end
  end

  assign run_o  = run_q;
  assign stat_o = stat_q;
  assign h_o    = h_q;
  assign v_o    = v_q;
endmodule

// File: rtl/dtg_axis_dec.sv
module dtg_axis_dec
  import dtg_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             run_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [REG_W-1:0] tot_i,
  input  logic [REG_W-1:0] blk_i,
  input  logic [REG_W-1:0] syn_i,
  output logic             sync_o,
  output logic             blank_o,
  output logic             act_o
);
  logic [CNT_W-1:0] act_last, blk_lo, blk_hi, syn_lo, syn_hi;

  assign act_last = tot_i[CNT_W-1:0];
  assign blk_lo   = blk_i[CNT_W-1:0];
  assign blk_hi   = blk_i[HALF_W +: CNT_W];
  assign syn_lo   = syn_i[CNT_W-1:0];
  assign syn_hi   = syn_i[HALF_W +: CNT_W];

  assign sync_o  = run_i && cnt_i >= syn_lo && cnt_i <= syn_hi;
  assign blank_o = cnt_i > blk_lo && cnt_i <= blk_hi;
  assign act_o   = cnt_i <= act_last;
endmodule

// File: rtl/disp_timing_gen.sv
module disp_timing_gen
  import dtg_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [2:0]        wr_addr_i,
  input  logic [31:0]       wr_data_i,
  input  logic [2:0]        rd_addr_i,
  output logic [31:0]       rd_data_o,
  input  logic              desc_load_i,
  input  logic [79:0]       desc_i,
  output logic              hsync_o,
  output logic              vsync_o,
  output logic              blank_o,
  output logic              de_o,
  output logic [CNT_W-1:0]  x_o,
  output logic [CNT_W-1:0]  y_o,
  output logic              frame_start_o,
  output logic              running_o
);
  tw_arr_t          desc_words, tw;
  logic             req_q, run_q, stat_q;
  logic [CNT_W-1:0] h_cnt, v_cnt;
  logic [REG_W-1:0] htot_w, vtot_w;
  logic [1:0]       ax_sync, ax_blank, ax_act;
  logic [CNT_W-1:0] ax_cnt [2];

  dtg_desc_conv u_conv (
    .desc_i  (desc_i),
    .words_o (desc_words)
  );

  dtg_regs u_regs (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .wr_en_i      (wr_en_i),
    .wr_addr_i    (wr_addr_i),
    .wr_data_i    (wr_data_i),
    .rd_addr_i    (rd_addr_i),
    .rd_data_o    (rd_data_o),
    .desc_load_i  (desc_load_i),
    .desc_words_i (desc_words),
    .stat_i       (stat_q),
    .req_o        (req_q),
    .tw_o         (tw)
  );

  assign htot_w = tw[W_HTOT];
  assign vtot_w = tw[W_VTOT];

  dtg_counters #(.CNT_W(CNT_W)) u_cnt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .req_i    (req_q),
    .h_last_i (htot_w[HALF_W +: CNT_W]),
    .v_last_i (vtot_w[HALF_W +: CNT_W]),
    .run_o    (run_q),
    .stat_o   (stat_q),
    .h_o      (h_cnt),
    .v_o      (v_cnt)
  );

  assign ax_cnt[0] = h_cnt;
  assign ax_cnt[1] = v_cnt;

  for (genvar a = 0; a < 2; a++) begin : g_axis
    localparam int BASE = (a == 0) ? W_HTOT : W_VTOT;
    dtg_axis_dec #(.CNT_W(CNT_W)) u_dec (
      .run_i   (run_q),
      .cnt_i   (ax_cnt[a]),
      .tot_i   (tw[BASE]),
      .blk_i   (tw[BASE+1]),
      .syn_i   (tw[BASE+2]),
      .sync_o  (ax_sync[a]),
      .blank_o (ax_blank[a]),
      .act_o   (ax_act[a])
    );
  end

  assign hsync_o       = ax_sync[0];
  assign vsync_o       = ax_sync[1];
  assign blank_o       = !run_q || (|ax_blank);
  assign de_o          = run_q && (&ax_act);
  assign x_o           = h_cnt;
  assign y_o           = v_cnt;
  assign frame_start_o = run_q && h_cnt == '0 && v_cnt == '0;
  assign running_o     = stat_q;
endmodule

// File: rtl/disp_timing_gen_chk.sv
module disp_timing_gen_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             hsync_i,
  input logic             vsync_i,
  input logic             blank_i,
  input logic             de_i,
  input logic [CNT_W-1:0] x_i,
  input logic [CNT_W-1:0] y_i,
  input logic             fs_i,
  input logic             run_i,
  input logic             req_i,
  input logic             stat_i,
  input logic [31:0]      htot_i,
  input logic [31:0]      vtot_i
);
  // R7: active video is never blanked
  assert_de_unblanked_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    de_i |-> !blank_i);

  // R6: stopped pipe stays quiet
  assert_idle_quiet_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |-> (blank_i && !hsync_i && !vsync_i && !de_i));

  // R8: counting only starts on a request
  assert_start_on_req_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(run_i) |-> $past(req_i));

  // R8: status trails the run state
  assert_status_lag_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(run_i) |=> stat_i);

  // R9: stop only right after the last pixel of the last line
  assert_stop_at_end_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(run_i) |-> ($past(x_i) == htot_i[16 +: CNT_W] && $past(y_i) == vtot_i[16 +: CNT_W]));

  // R4: pixel counter steps by one inside a line
  assert_x_step_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && $past(run_i) && x_i != '0) |-> x_i == $past(x_i) + CNT_W'(1));

  // R3: timing words frozen while not idle
  assert_frozen_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i || stat_i) |=> ($stable(htot_i) && $stable(vtot_i)));

  // R12: frame start only at origin
  assert_fs_origin_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fs_i |-> (x_i == '0 && y_i == '0 && run_i));
endmodule

bind disp_timing_gen disp_timing_gen_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .hsync_i (hsync_o),
  .vsync_i (vsync_o),
  .blank_i (blank_o),
  .de_i    (de_o),
  .x_i     (x_o),
  .y_i     (y_o),
  .fs_i    (frame_start_o),
  .run_i   (run_q),
  .req_i   (req_q),
  .stat_i  (stat_q),
  .htot_i  (htot_w),
  .vtot_i  (vtot_w)
);

// File: tb/tb_disp_timing_gen.sv
`timescale 1ns/1ps
module tb_disp_timing_gen;
  localparam int CW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0;
  logic [2:0]    wr_addr = '0;
  logic [31:0]   wr_data = '0;
  logic [2:0]    rd_addr = '0;
  logic [31:0]   rd_data;
  logic          desc_load = 1'b0;
  logic [79:0]   desc = '0;
  logic          hsync, vsync, blank, de, fstart, running;
  logic [CW-1:0] x, y;

  always #10 clk = ~clk;

  disp_timing_gen #(.CNT_W(CW)) dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .rd_addr_i(rd_addr), .rd_data_o(rd_data),
    .desc_load_i(desc_load), .desc_i(desc), .hsync_o(hsync), .vsync_o(vsync),
    .blank_o(blank), .de_o(de), .x_o(x), .y_o(y), .frame_start_o(fstart),
    .running_o(running)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit chk_on = 0;
  bit done = 0;
  string ph = "R1";

  // reference model state
  int m_h, m_v;
  bit m_req, m_run, m_stat;
  logic [31:0] m_reg [1:7];
  logic [31:0] d_word [1:7];

  function automatic int lo(logic [31:0] w); return int'(w[15:0]); endfunction
  function automatic int hi(logic [31:0] w); return int'(w[31:16]); endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_h = 0; m_v = 0; m_req = 0; m_run = 0; m_stat = 0;
      for (int i = 1; i <= 7; i++) m_reg[i] = '0;
    end else begin
      int nh, nv; bit nrun, nreq, idle;
      idle = !m_req && !m_stat;
      if (m_run) begin
        if (m_h == hi(m_reg[1])) begin
          nh = 0;
          nv = (m_v == hi(m_reg[4])) ? 0 : m_v + 1;
        end else begin
          nh = m_h + 1; nv = m_v;
        end
        nrun = !(m_h == hi(m_reg[1]) && m_v == hi(m_reg[4]) && !m_req);
      end else begin
        nh = 0; nv = 0; nrun = m_req;
      end
      nreq = m_req;
      if (wr_en && wr_addr == 3'd0) nreq = wr_data[31];
      if (idle) begin
        if (desc_load) for (int i = 1; i <= 7; i++) m_reg[i] = d_word[i];
        else if (wr_en && wr_addr != 3'd0) m_reg[wr_addr] = wr_data;
      end
      m_stat = m_run; m_run = nrun; m_req = nreq; m_h = nh; m_v = nv;
    end
  end

  task automatic cmp(string tag, string nm, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, nm, act, exp);
    end
  endtask

  always @(negedge clk) if (chk_on) begin
    bit e_hs, e_vs, e_bl, e_de, e_fs;
    logic [31:0] e_rd;
    e_hs = m_run && m_h >= lo(m_reg[3]) && m_h <= hi(m_reg[3]);
    e_vs = m_run && m_v >= lo(m_reg[6]) && m_v <= hi(m_reg[6]);
    e_bl = !m_run || (m_h > lo(m_reg[2]) && m_h <= hi(m_reg[2]))
                  || (m_v > lo(m_reg[5]) && m_v <= hi(m_reg[5]));
    e_de = m_run && m_h <= lo(m_reg[1]) && m_v <= lo(m_reg[4]);
    e_fs = m_run && m_h == 0 && m_v == 0;
    e_rd = (rd_addr == 3'd0) ? {m_req, m_stat, 30'd0} : m_reg[rd_addr];
    cmp("R4", "x", 32'(x), 32'(m_h));
    cmp("R4", "y", 32'(y), 32'(m_v));
    cmp("R5", "hsync", 32'(hsync), 32'(e_hs));
    cmp("R5", "vsync", 32'(vsync), 32'(e_vs));
    cmp("R6", "blank", 32'(blank), 32'(e_bl));
    cmp("R7", "de", 32'(de), 32'(e_de));
    cmp("R12", "frame_start", 32'(fstart), 32'(e_fs));
    cmp("R8", "running", 32'(running), 32'(m_stat));
    cmp(ph, "rd_data", rd_data, e_rd);
  end

  task automatic step(int n);
    repeat (n) @(negedge clk);
    #2;
  endtask

  task automatic wr(logic [2:0] a, logic [31:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    step(1);
    wr_en = 1'b0;
  endtask

  task automatic set_desc(logic [11:0] ha, logic [11:0] hb, logic [9:0] hso, logic [9:0] hpw,
                          logic [11:0] va, logic [11:0] vb, logic [5:0] vso, logic [5:0] vpw);
    int ht, vt;
    desc = {hso[9:8], hpw[9:8], vso[5:4], vpw[5:4], vso[3:0], vpw[3:0], hpw[7:0], hso[7:0],
            va[11:8], vb[11:8], vb[7:0], va[7:0], ha[11:8], hb[11:8], hb[7:0], ha[7:0]};
    ht = ha + hb; vt = va + vb;
    d_word[1] = {16'(ht - 1), 16'(ha - 1)};
    d_word[2] = d_word[1];
    d_word[3] = {16'(ha + hso + hpw - 1), 16'(ha + hso - 1)};
    d_word[4] = {16'(vt - 1), 16'(va - 1)};
    d_word[5] = d_word[4];
    d_word[6] = {16'(va + vso + vpw - 1), 16'(va + vso - 1)};
    d_word[7] = {16'(ha - 1), 16'(va - 1)};
  endtask

  task automatic sweep();
    for (int a = 1; a <= 7; a++) begin
      rd_addr = 3'(a);
      step(1);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      summary();
      $finish;
    end
  end

  initial begin
    for (int i = 1; i <= 7; i++) d_word[i] = '0;
    step(3);
    chk_on = 1;                      // R1: reset values
    step(1);
    rst_n = 1'b1;
    step(2);
    sweep();

    ph = "R2";                       // direct programming, 12x6 frame
    rd_addr = 3'd1; wr(3'd1, {16'd11, 16'd7});
    rd_addr = 3'd2; wr(3'd2, {16'd11, 16'd7});
    rd_addr = 3'd3; wr(3'd3, {16'd9, 16'd8});
    rd_addr = 3'd4; wr(3'd4, {16'd5, 16'd3});
    rd_addr = 3'd5; wr(3'd5, {16'd5, 16'd3});
    rd_addr = 3'd6; wr(3'd6, {16'd4, 16'd4});
    rd_addr = 3'd7; wr(3'd7, {16'd7, 16'd3});
    step(1);

    ph = "R8";
    rd_addr = 3'd0;
    wr(3'd0, 32'h8000_0000);
    step(150);

    ph = "R3";
    rd_addr = 3'd1;
    wr(3'd1, 32'h0005_0003);
    step(2);

    ph = "R11";
    set_desc(12'd10, 12'd6, 10'd2, 10'd3, 12'd3, 12'd3, 6'd1, 6'd1);
    rd_addr = 3'd2;
    desc_load = 1'b1; step(1); desc_load = 1'b0;
    step(2);

    ph = "R9";
    rd_addr = 3'd0;
    step(17);
    wr(3'd0, 32'h0);
    step(90);

    ph = "R10";
    desc_load = 1'b1; step(1); desc_load = 1'b0;
    sweep();
    rd_addr = 3'd0;
    ph = "R8";
    wr(3'd0, 32'h8000_0000);
    step(200);
    ph = "R9";
    wr(3'd0, 32'h0);
    step(110);

    ph = "R10";
    set_desc(12'h2D0, 12'h1A0, 10'h110, 10'h02A, 12'h1E0, 12'h02D, 6'h21, 6'h12);
    desc_load = 1'b1; step(1); desc_load = 1'b0;
    sweep();

    ph = "R2";
    rd_addr = 3'd3; wr(3'd3, 32'hABCD_1234);
    step(2);

    chk_on = 0;
    done = 1;
    summary();
    $finish;
  end
endmodule